// File: doc/BRIEF.md
# Cartridge Bank Mapper

The mapper sits between a 20-bit CPU address bus and external cartridge ROM and battery-backed SRAM. It decodes which of four CPU windows an access falls into and substitutes an 8-bit bank number for the upper address bits. Three window kinds exist: a 64 KiB SRAM window, two 64 KiB ROM windows that each have a bank register of their own, and one large ROM window spanning the top of the address map. The large window keeps all 20 CPU address bits and puts its bank number above them.

Each physical address is trimmed to the size of the memory behind it. That size is rounded up to a power of two, so an access beyond the end of a part whose size is not a power of two lands in a mirrored copy and never faults. A memory whose size parameter is zero is treated as absent. Accesses to it assert no select and read back zero. A small write port loads the four bank registers, and reset sets every one of them to all ones.

Top module: `cartBankMapper`

## Requirements
- R1: After reset every bank register holds 0xFF, so the first accesses use bank 0xFF in every window.
- R2: The window is chosen by CPU address bits 19:16 alone. Value 0 selects nothing, 1 selects SRAM, 2 and 3 select the two small ROM windows, and 4 through 15 select the large ROM window.
- R3: For an SRAM access the physical address is the SRAM bank in bits 23:16 and CPU address bits 15:0 below it, masked by the SRAM mask.
- R4: In window 2 the ROM address is the first small-window bank in bits 23:16 over CPU bits 15:0. Window 3 is built the same way from the second small-window bank. Both are masked by the ROM mask.
- R5: In the large window the ROM address is the large-window bank in bits 27:20 over all 20 CPU address bits, masked by the ROM mask.
- R6: Each mask equals the memory size rounded up to a power of two, minus one. Banks that differ only above the mask reach the same physical address.
- R7: Writing the bank port with index 0 loads the SRAM bank. Index 1 loads the window-2 bank, index 2 the window-3 bank and index 3 the large-window bank. The new value applies to accesses presented on later cycles.
- R8: Selects, the SRAM write enable, the physical addresses and the SRAM write data are registered. They appear one cycle after the access is presented, and both selects are low in a cycle that follows no access.
- R9: A write into any ROM window asserts neither select nor the SRAM write enable.
- R10: When a memory size parameter is zero, accesses to that memory assert no select and cpuRData reads 0x00.
- R11: During a ROM read cpuRData carries romRData. During an SRAM read it carries ramRData. Otherwise it is 0x00.
- R12: An SRAM write asserts ramSel and ramWrEn and presents the CPU write data on ramWData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Access presented this cycle |
| cpuWe | input | 1 | Access is a write |
| cpuAddr | input | 20 | CPU byte address |
| cpuWData | input | 8 | CPU write data |
| cpuRData | output | 8 | Read data returned to the CPU |
| bankWrEn | input | 1 | Load a bank register |
| bankIdx | input | 2 | Bank register index (0 SRAM, 1 window 2, 2 window 3, 3 large window) |
| bankWData | input | 8 | New bank value |
| romSel | output | 1 | ROM read strobe |
| romAddr | output | 28 | Masked ROM physical address |
| romRData | input | 8 | ROM read data |
| ramSel | output | 1 | SRAM access strobe |
| ramWrEn | output | 1 | SRAM write enable |
| ramAddr | output | 24 | Masked SRAM physical address |
| ramWData | output | 8 | SRAM write data |
| ramRData | input | 8 | SRAM read data |

## Verification
Every access result (selects, write enable, physical addresses and write data) is due exactly one clock after the cycle in which the access is presented. The read data follows from those registered selects in that same cycle. A bank write changes nothing in its own cycle and affects only accesses presented afterwards. The driver stamps each expected item with the cycle it is due in. The monitor pops an item only when the cycle count matches that stamp and samples on the falling edge, so results from neighbouring accesses are never mixed up. A second instance with both sizes zero receives the same stimulus, and its outputs are compared against the empty-memory expectation on every item.

// File: rtl/cartmap_pkg.sv
package cartmap_pkg;
  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_SRAM,
    WIN_ROM_A,
    WIN_ROM_B,
    WIN_ROM_BIG
  } mapWin_e;

  typedef struct packed {
    logic       romRd;
    logic       ramRd;
    logic       ramWr;
    mapWin_e    win;
    logic       bankWr;
    logic [1:0] bankIdx;
  } mapStrobe_t;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 8;
  localparam int CPU_AW    = 20;
  localparam int ROM_PW    = 28;
  localparam int RAM_PW    = 24;
endpackage

// File: rtl/cartMapCtrl.sv
module cartMapCtrl
  import cartmap_pkg::*;
#(
  parameter bit ROM_PRESENT = 1'b1,
  parameter bit RAM_PRESENT = 1'b1
) (
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic [3:0] winBits,
  input  logic       bankWrEn,
  input  logic [1:0] bankIdx,
  output mapStrobe_t strobe
);
  mapWin_e win;
  logic    isRom;

  always_comb begin
    unique case (winBits)
      4'h0:    win = WIN_NONE;
      4'h1:    win = WIN_SRAM;
      4'h2:    win = WIN_ROM_A;
      4'h3:    win = WIN_ROM_B;
      default: win = WIN_ROM_BIG;
    endcase
    isRom = (win == WIN_ROM_A) || (win == WIN_ROM_B) || (win == WIN_ROM_BIG);
  end

  always_comb begin
    strobe.win     = win;
    strobe.romRd   = cpuReq && !cpuWe && ROM_PRESENT && isRom;
    strobe.ramRd   = cpuReq && !cpuWe && RAM_PRESENT && (win == WIN_SRAM);
    strobe.ramWr   = cpuReq &&  cpuWe && RAM_PRESENT && (win == WIN_SRAM);
    strobe.bankWr  = bankWrEn;
    strobe.bankIdx = bankIdx;
  end
endmodule

// File: rtl/cartMapDp.sv
module cartMapDp
  import cartmap_pkg::*;
#(
  parameter logic [ROM_PW-1:0] ROM_MASK = '1,
  parameter logic [RAM_PW-1:0] RAM_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [7:0]        cpuWData,
  input  logic [BANK_W-1:0] bankWData,
  input  logic [7:0]        romRData,
  input  logic [7:0]        ramRData,
  output logic              romSel,
  output logic [ROM_PW-1:0] romAddr,
  output logic              ramSel,
  output logic              ramWrEn,
  output logic [RAM_PW-1:0] ramAddr,
  output logic [7:0]        ramWData,
  output logic [7:0]        cpuRData
);
  logic [BANK_W-1:0] bankReg [NUM_BANKS];
  logic [ROM_PW-1:0] romRaw;
  logic [RAM_PW-1:0] ramRaw;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankReg[i] <= '1;
      else if (strobe.bankWr && strobe.bankIdx == 2'(i))
        bankReg[i] <= bankWData;
    end
  end

  always_comb begin
    unique case (strobe.win)
      WIN_ROM_A: romRaw = {4'h0, bankReg[1], cpuAddr[15:0]};
      WIN_ROM_B: romRaw = {4'h0, bankReg[2], cpuAddr[15:0]};
      default:   romRaw = {bankReg[3], cpuAddr};
    endcase
    ramRaw = {bankReg[0], cpuAddr[15:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romSel   <= 1'b0;
      ramSel   <= 1'b0;
      ramWrEn  <= 1'b0;
      romAddr  <= '0;
      ramAddr  <= '0;
      ramWData <= '0;
    end else begin
      romSel  <= strobe.romRd;
      ramSel  <= strobe.ramRd || strobe.ramWr;
      ramWrEn <= strobe.ramWr;
      if (strobe.romRd)
        romAddr <= romRaw & ROM_MASK;
      if (strobe.ramRd || strobe.ramWr)
        ramAddr <= ramRaw & RAM_MASK;
      if (strobe.ramWr)
        ramWData <= cpuWData;
    end
  end

  always_comb begin
    if (romSel)
      cpuRData = romRData;
    else if (ramSel && !ramWrEn)
      cpuRData = ramRData;
    else
      cpuRData = 8'h00;
  end
endmodule

// File: rtl/cartBankMapper.sv
module cartBankMapper
  import cartmap_pkg::*;
#(
  parameter int unsigned ROM_BYTES = 1572864,
  parameter int unsigned RAM_BYTES = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic [19:0] cpuAddr,
  input  logic [7:0]  cpuWData,
  output logic [7:0]  cpuRData,
  input  logic        bankWrEn,
  input  logic [1:0]  bankIdx,
  input  logic [7:0]  bankWData,
  output logic        romSel,
  output logic [27:0] romAddr,
  input  logic [7:0]  romRData,
  output logic        ramSel,
  output logic        ramWrEn,
  output logic [23:0] ramAddr,
  output logic [7:0]  ramWData,
  input  logic [7:0]  ramRData
);
  localparam int ROM_AW = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1;
  localparam int RAM_AW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
  localparam logic [ROM_PW-1:0] ROM_MASK = ROM_PW'((64'd1 << ROM_AW) - 64'd1);
  localparam logic [RAM_PW-1:0] RAM_MASK = RAM_PW'((64'd1 << RAM_AW) - 64'd1);

  mapStrobe_t strobe;

  cartMapCtrl #(
    .ROM_PRESENT(ROM_BYTES != 0),
    .RAM_PRESENT(RAM_BYTES != 0)
  ) uCtrl (
    .cpuReq  (cpuReq),
    .cpuWe   (cpuWe),
    .winBits (cpuAddr[19:16]),
    .bankWrEn(bankWrEn),
    .bankIdx (bankIdx),
    .strobe  (strobe)
  );

  cartMapDp #(
    .ROM_MASK(ROM_MASK),
    .RAM_MASK(RAM_MASK)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuAddr  (cpuAddr),
    .cpuWData (cpuWData),
    .bankWData(bankWData),
    .romRData (romRData),
    .ramRData (ramRData),
    .romSel   (romSel),
    .romAddr  (romAddr),
    .ramSel   (ramSel),
    .ramWrEn  (ramWrEn),
    .ramAddr  (ramAddr),
    .ramWData (ramWData),
    .cpuRData (cpuRData)
  );
endmodule

// File: rtl/cartMapChecker.sv
module cartMapChecker #(
  parameter int unsigned ROM_BYTES = 1,
  parameter int unsigned RAM_BYTES = 1
) (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuWe,
  input logic [3:0]  cpuWin,
  input logic [7:0]  cpuWData,
  input logic        romSel,
  input logic [27:0] romAddr,
  input logic        ramSel,
  input logic        ramWrEn,
  input logic [23:0] ramAddr,
  input logic [7:0]  ramWData,
  input logic [7:0]  cpuRData
);
  localparam int CHK_ROM_AW = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1;
  localparam int CHK_RAM_AW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
  localparam logic [27:0] ROM_LIMIT = 28'((64'd1 << CHK_ROM_AW) - 64'd1);
  localparam logic [23:0] RAM_LIMIT = 24'((64'd1 << CHK_RAM_AW) - 64'd1);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |=> (!romSel && !ramSel));

  // R2
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, ramSel}));

  // R2
  low_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWin == 4'h0) |=> (!romSel && !ramSel));

  // R9
  rom_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && cpuWin[3:1] != 3'b000) |=> (!romSel && !ramWrEn));

  // R12
  wren_has_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> ramSel);

  // R12
  wdata_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (ramWData == $past(cpuWData)));

  // R6
  rom_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> ((romAddr & ~ROM_LIMIT) == 28'h0));

  // R6
  ram_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |-> ((ramAddr & ~RAM_LIMIT) == 24'h0));

  // R11
  no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!romSel && !ramSel) |-> (cpuRData == 8'h00));
endmodule

bind cartBankMapper cartMapChecker #(
  .ROM_BYTES(ROM_BYTES),
  .RAM_BYTES(RAM_BYTES)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuWin  (cpuAddr[19:16]),
  .cpuWData(cpuWData),
  .romSel  (romSel),
  .romAddr (romAddr),
  .ramSel  (ramSel),
  .ramWrEn (ramWrEn),
  .ramAddr (ramAddr),
  .ramWData(ramWData),
  .cpuRData(cpuRData)
);

// File: tb/tb_cartBankMapper.sv
`timescale 1ns/1ps
module tb_cartBankMapper;
  localparam int unsigned ROM_BYTES = 1572864;
  localparam int unsigned RAM_BYTES = 100000;
  localparam logic [7:0] ROM_DATA = 8'hA5;
  localparam logic [7:0] RAM_DATA = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0, bankWrEn = 1'b0;
  logic [19:0] cpuAddr = '0;
  logic [7:0] cpuWData = '0, bankWData = '0;
  logic [1:0] bankIdx = '0;
  logic [7:0] romRData = ROM_DATA, ramRData = RAM_DATA;

  logic [7:0]  cpuRData, eRData;
  logic        romSel, ramSel, ramWrEn, eRomSel, eRamSel, eRamWrEn;
  logic [27:0] romAddr, eRomAddr;
  logic [23:0] ramAddr, eRamAddr;
  logic [7:0]  ramWData, eRamWData;

  always #4 clk = ~clk;

  cartBankMapper #(.ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES)) dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuRData(cpuRData), .bankWrEn(bankWrEn), .bankIdx(bankIdx),
    .bankWData(bankWData), .romSel(romSel), .romAddr(romAddr), .romRData(romRData),
    .ramSel(ramSel), .ramWrEn(ramWrEn), .ramAddr(ramAddr), .ramWData(ramWData),
    .ramRData(ramRData));

  cartBankMapper #(.ROM_BYTES(0), .RAM_BYTES(0)) dutEmpty (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuRData(eRData), .bankWrEn(bankWrEn), .bankIdx(bankIdx),
    .bankWData(bankWData), .romSel(eRomSel), .romAddr(eRomAddr), .romRData(romRData),
    .ramSel(eRamSel), .ramWrEn(eRamWrEn), .ramAddr(eRamAddr), .ramWData(eRamWData),
    .ramRData(ramRData));

  typedef struct {
    int          due;
    string       tag;
    logic        romSel;
    logic        ramSel;
    logic        ramWrEn;
    logic [27:0] romAddr;
    logic [23:0] ramAddr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
  } expItem_t;

  expItem_t q[$];
  int total = 0, bad = 0, cycle = 0;
  logic [7:0] mBank [4];
  logic [27:0] romMask;
  logic [23:0] ramMask;

  function automatic longint unsigned pow2ceil(longint unsigned n);
    longint unsigned p = 1;
    while (p < n) p = p << 1;
    return p;
  endfunction

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops an item only in the cycle it is due
  always @(negedge clk) begin
    if (rstN && q.size() > 0 && q[0].due == cycle) begin
      expItem_t it;
      it = q.pop_front();
      check(romSel == it.romSel, it.tag, "romSel", romSel, it.romSel);
      check(ramSel == it.ramSel, it.tag, "ramSel", ramSel, it.ramSel);
      check(ramWrEn == it.ramWrEn, it.tag, "ramWrEn", ramWrEn, it.ramWrEn);
      check(cpuRData == it.rdata, it.tag, "cpuRData", cpuRData, it.rdata);
      if (it.romSel) check(romAddr == it.romAddr, it.tag, "romAddr", romAddr, it.romAddr);
      if (it.ramSel) check(ramAddr == it.ramAddr, it.tag, "ramAddr", ramAddr, it.ramAddr);
      if (it.ramWrEn) check(ramWData == it.wdata, it.tag, "ramWData", ramWData, it.wdata);
      // R10: empty instance never selects and reads zero
      check(!eRomSel && !eRamSel && !eRamWrEn && eRData == 8'h00, "R10", "empty outputs",
            {eRomSel, eRamSel, eRamWrEn, eRData}, 0);
    end
  end

  // Driver: one cycle of stimulus plus its expected result one cycle later
  task automatic access(input bit req, input bit we, input logic [19:0] a,
                        input logic [7:0] d, input string tag);
    expItem_t it;
    logic [3:0] w;
    @(negedge clk);
    cpuReq = req; cpuWe = we; cpuAddr = a; cpuWData = d; bankWrEn = 1'b0;
    w = a[19:16];
    it.due = cycle + 1; it.tag = tag;
    it.romSel = req && !we && (w >= 4'h2);
    it.ramSel = req && (w == 4'h1);
    it.ramWrEn = req && we && (w == 4'h1);
    if (w == 4'h2)      it.romAddr = {4'h0, mBank[1], a[15:0]} & romMask;
    else if (w == 4'h3) it.romAddr = {4'h0, mBank[2], a[15:0]} & romMask;
    else                it.romAddr = {mBank[3], a} & romMask;
    it.ramAddr = {mBank[0], a[15:0]} & ramMask;
    it.wdata = d;
    it.rdata = it.romSel ? ROM_DATA : ((it.ramSel && !we) ? RAM_DATA : 8'h00);
    q.push_back(it);
  endtask

  // R7 bank write: no access this cycle, so the next cycle expects quiet outputs
  task automatic setBank(input logic [1:0] idx, input logic [7:0] v);
    expItem_t it;
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0; bankWrEn = 1'b1; bankIdx = idx; bankWData = v;
    mBank[idx] = v;
    it = '{due: cycle + 1, tag: "R7", romSel: 0, ramSel: 0, ramWrEn: 0,
           romAddr: 0, ramAddr: 0, wdata: 0, rdata: 0};
    q.push_back(it);
  endtask

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    romMask = 28'(pow2ceil(ROM_BYTES) - 1);
    ramMask = 24'(pow2ceil(RAM_BYTES) - 1);
    for (int i = 0; i < 4; i++) mBank[i] = 8'hFF;   // R1 reset value
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    access(0, 0, 20'h0, 8'h0, "R8");                 // reset state quiet
    // R1 / R3 / R4 / R5 with reset banks
    access(1, 0, 20'h21234, 8'h0, "R4");
    access(1, 0, 20'h3ABCD, 8'h0, "R4");
    access(1, 0, 20'h45678, 8'h0, "R5");
    access(1, 0, 20'hFFFFF, 8'h0, "R5");
    access(1, 0, 20'h10042, 8'h0, "R3");
    // R2 low window selects nothing
    access(1, 0, 20'h0ABCD, 8'h0, "R2");
    access(1, 0, 20'hE0001, 8'h0, "R2");
    // R7 reprogram banks
    setBank(2'd0, 8'h02);
    setBank(2'd1, 8'h05);
    setBank(2'd2, 8'h13);
    setBank(2'd3, 8'h07);
    access(1, 0, 20'h10010, 8'h0, "R3");
    access(1, 0, 20'h20020, 8'h0, "R4");
    access(1, 0, 20'h30030, 8'h0, "R4");
    access(1, 0, 20'h9C0DE, 8'h0, "R5");
    access(0, 0, 20'h20020, 8'h0, "R8");             // idle after a read
    // R6 mirroring: bank 0x25 lands on bank 0x05 under the rounded ROM size
    setBank(2'd1, 8'h25);
    access(1, 0, 20'h20020, 8'h0, "R6");
    setBank(2'd0, 8'h03);                            // RAM mask keeps bank bit 0
    access(1, 0, 20'h1FFFF, 8'h0, "R6");
    // R12 SRAM write, R11 reads on both memories
    access(1, 1, 20'h10777, 8'h5A, "R12");
    access(1, 0, 20'h10777, 8'h0, "R11");
    access(1, 0, 20'h2ABCD, 8'h0, "R11");
    // R9 writes into ROM windows do nothing
    access(1, 1, 20'h20000, 8'h11, "R9");
    access(1, 1, 20'h3FFFF, 8'h22, "R9");
    access(1, 1, 20'h80000, 8'h33, "R9");
    access(0, 0, 20'h0, 8'h0, "R8");
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) check(0, "R8", "pending items", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule